// File: doc/BRIEF.md
# Modem and Line Status Reporter

This block watches four modem input lines (carrier detect, ring, data set ready, clear to send) and the serial status signals of a receiver and transmitter. From them it keeps two status bytes. The modem status byte holds the present line levels and sticky change flags. The line status byte holds the buffer levels and sticky error flags. A host can read both bytes at any time through `msr_out` and `lsr_out`. A one-cycle `rd_strobe` marks a read and clears the sticky flags.

When a modem line moves or an error pulse arrives, the block sends a two-byte report on a valid/ready stream on its own. The modem status byte goes first and the line status byte goes second, marked by `rpt_last`. A small state machine carries the report.

Its states are:
- ST_IDLE: nothing is being sent.
- ST_SEND_MSR: the first byte is offered.
- ST_SEND_LSR: the second byte is offered.

Its transitions are:
- launch: ST_IDLE to ST_SEND_MSR, taken when a request is pending. It captures both bytes and clears the sticky flags.
- first_taken: ST_SEND_MSR to ST_SEND_LSR, on valid and ready.
- last_taken: ST_SEND_LSR to ST_IDLE, on valid and ready.

Top module: `modem_line_status_rpt`

## Requirements
- R1: `msr_out[7:4]` shows the levels of carrier detect, ring, data set ready and clear to send (bits 7, 6, 5, 4), registered one cycle after `modem_lvl`. `modem_lvl` bit 3 is carrier detect, bit 2 is ring, bit 1 is data set ready and bit 0 is clear to send.
- R2: `msr_out` bits 3, 1 and 0 become 1 and stay 1 when carrier detect, data set ready or clear to send, respectively, changes level one or more times.
- R3: `msr_out` bit 2 becomes 1 only when ring falls from 1 to 0. A rising ring line leaves it unchanged.
- R4: In `lsr_out`, bit 0 mirrors `rx_ready`, bit 5 mirrors `thr_empty` and bit 6 mirrors `tx_empty`, each registered one cycle. Bits 1, 2, 3 and 4 latch the overrun, parity, framing and break pulses.
- R5: `lsr_out` bit 7 is 1 exactly when a latched parity, framing or break flag is set. Overrun does not affect it.
- R6: `rd_strobe` clears all modem change flags and all line error flags from the next cycle. An event arriving in the same cycle as the read is kept.
- R7: A report is two stream bytes: the modem status byte with `rpt_last`=0, then the line status byte with `rpt_last`=1. Data and last hold steady while `rpt_valid` is high and `rpt_ready` is low.
- R8: A report is requested by any level change on `modem_lvl` (either direction, including ring) or by any error pulse. Changes of `rx_ready`, `thr_empty` or `tx_empty` alone request none.
- R9: Launching a report captures both bytes and clears the sticky flags, keeping events of that same cycle. Requests made while a report is pending or in flight merge into a single following report.
- R10: After reset, with all inputs low, both status bytes read 0x00 and no report is offered. The lines are compared against a baseline of all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modem_lvl | input | 4 | Synchronized modem levels: CD, RI, DSR, CTS (bits 3..0) |
| err_overrun | input | 1 | One-cycle overrun pulse |
| err_parity | input | 1 | One-cycle parity error pulse |
| err_framing | input | 1 | One-cycle framing error pulse |
| err_break | input | 1 | One-cycle break pulse |
| rx_ready | input | 1 | Receive data available level |
| thr_empty | input | 1 | Holding register empty level |
| tx_empty | input | 1 | Transmitter fully idle level |
| rd_strobe | input | 1 | Host read; clears sticky flags |
| rpt_ready | input | 1 | Report sink can accept a byte |
| rpt_valid | output | 1 | Report byte offered |
| rpt_data | output | 8 | Report byte |
| rpt_last | output | 1 | Marks the second (final) report byte |
| msr_out | output | 8 | Live modem status byte |
| lsr_out | output | 8 | Live line status byte |

## Verification
The status bytes are driven by a sequence of vectors that raise and drop each modem line in turn. This separates per-line change tracking from the ring rule: a rising ring must leave bit 2 clear, and a falling ring must set it. Error pulses are mixed with level changes and reads, including a read in the same cycle as a new event. This tells apart a clear that wins from a set that wins, and shows that overrun is kept out of bit 7. Directed runs hold the stream sink stalled while several events arrive, then release it. Exactly two reports must follow, carrying the captured values, which shows merging and capture at launch. Changing only status levels must produce no report.

// File: rtl/mlsr_pkg.sv
package mlsr_pkg;
    localparam int BYTE_W = 8;
    localparam int LINE_N = 4;
    localparam int ERR_N  = 4;
    // line index order fixes the bit order of both nibbles of the modem byte
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_CD  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND_MSR,
        ST_SEND_LSR
    } rpt_state_t;
endpackage

// File: rtl/mlsr_modem_track.sv
module mlsr_modem_track
    import mlsr_pkg::*;
#(
    parameter int N = LINE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      lvl,
    input  logic              clr,
    output logic [2*N-1:0]    msr,
    output logic              change
);
    logic [N-1:0] lvl_q;
    logic [N-1:0] delta_q;
    logic [N-1:0] set_v;

    // per-line change detect; the ring line only flags its trailing edge
    for (genvar i = 0; i < N; i++) begin : g_line
        if (i == L_RI) begin : g_trail
            assign set_v[i] = lvl_q[i] & ~lvl[i];
        end else begin : g_any
            assign set_v[i] = lvl_q[i] ^ lvl[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            delta_q <= '0;
        end else begin
            lvl_q   <= lvl;
            delta_q <= set_v | (delta_q & ~{N{clr}});
        end
    end

    assign change = |(lvl ^ lvl_q);
    assign msr    = {lvl_q, delta_q};
endmodule

// File: rtl/mlsr_line_track.sv
module mlsr_line_track
    import mlsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_N-1:0]  err_pulse,
    input  logic              rx_ready,
    input  logic              thr_empty,
    input  logic              tx_empty,
    input  logic              clr,
    output logic [BYTE_W-1:0] lsr,
    output logic              err_evt
);
    // err_pulse order: 3 break, 2 framing, 1 parity, 0 overrun
    logic [ERR_N-1:0] sticky_q;
    logic             rx_q;
    logic             thr_q;
    logic             tx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            rx_q     <= 1'b0;
            thr_q    <= 1'b0;
            tx_q     <= 1'b0;
        end else begin
            sticky_q <= err_pulse | (sticky_q & ~{ERR_N{clr}});
            rx_q     <= rx_ready;
            thr_q    <= thr_empty;
            tx_q     <= tx_empty;
        end
    end

    assign err_evt = |err_pulse;
    assign lsr     = {|sticky_q[ERR_N-1:1], tx_q, thr_q, sticky_q, rx_q};
endmodule

// File: rtl/mlsr_report_fsm.sv
module mlsr_report_fsm
    import mlsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_evt,
    input  logic [BYTE_W-1:0] msr,
    input  logic [BYTE_W-1:0] lsr,
    input  logic              rpt_ready,
    output logic              rpt_valid,
    output logic [BYTE_W-1:0] rpt_data,
    output logic              rpt_last,
    output logic              launch
);
    rpt_state_t        state_q;
    rpt_state_t        state_d;
    logic              pend_q;
    logic [BYTE_W-1:0] snap_msr_q;
    logic [BYTE_W-1:0] snap_lsr_q;

    assign launch = (state_q == ST_IDLE) && pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (pend_q)    state_d = ST_SEND_MSR;
            ST_SEND_MSR: if (rpt_ready) state_d = ST_SEND_LSR;
            ST_SEND_LSR: if (rpt_ready) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= 1'b0;
            snap_msr_q <= '0;
            snap_lsr_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= req_evt | (pend_q & ~launch);
            if (launch) begin
                snap_msr_q <= msr;
                snap_lsr_q <= lsr;
            end
        end
    end

    always_comb begin
        rpt_valid = 1'b0;
        rpt_data  = '0;
        rpt_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND_MSR: begin
                rpt_valid = 1'b1;
                rpt_data  = snap_msr_q;
            end
            ST_SEND_LSR: begin
                rpt_valid = 1'b1;
                rpt_data  = snap_lsr_q;
                rpt_last  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/modem_line_status_rpt.sv
module modem_line_status_rpt
    import mlsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_N-1:0] modem_lvl,
    input  logic              err_overrun,
    input  logic              err_parity,
    input  logic              err_framing,
    input  logic              err_break,
    input  logic              rx_ready,
    input  logic              thr_empty,
    input  logic              tx_empty,
    input  logic              rd_strobe,
    input  logic              rpt_ready,
    output logic              rpt_valid,
    output logic [BYTE_W-1:0] rpt_data,
    output logic              rpt_last,
    output logic [BYTE_W-1:0] msr_out,
    output logic [BYTE_W-1:0] lsr_out
);
    logic launch;
    logic clr;
    logic modem_chg;
    logic err_evt;

    assign clr = rd_strobe | launch;

    mlsr_modem_track #(.N(LINE_N)) u_modem (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (modem_lvl),
        .clr    (clr),
        .msr    (msr_out),
        .change (modem_chg)
    );

    mlsr_line_track u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse ({err_break, err_framing, err_parity, err_overrun}),
        .rx_ready  (rx_ready),
        .thr_empty (thr_empty),
        .tx_empty  (tx_empty),
        .clr       (clr),
        .lsr       (lsr_out),
        .err_evt   (err_evt)
    );

    mlsr_report_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_evt   (modem_chg | err_evt),
        .msr       (msr_out),
        .lsr       (lsr_out),
        .rpt_ready (rpt_ready),
        .rpt_valid (rpt_valid),
        .rpt_data  (rpt_data),
        .rpt_last  (rpt_last),
        .launch    (launch)
    );
endmodule

// File: rtl/modem_line_status_rpt_chk.sv
module modem_line_status_rpt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] modem_lvl,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       rpt_ready,
    input logic       rpt_valid,
    input logic [7:0] rpt_data,
    input logic       rpt_last,
    input logic [7:0] msr_out,
    input logic [7:0] lsr_out
);
    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> msr_out[7:4] == $past(modem_lvl));

    // R5
    parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> (lsr_out[2] && lsr_out[7]));

    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> lsr_out[1]);

    // R7
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_last |-> rpt_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_data) && $stable(rpt_last)));

    // R7
    first_then_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_ready && !rpt_last) |=> (rpt_valid && rpt_last));

    // R7
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_ready && rpt_last) |=> !rpt_valid);
endmodule

bind modem_line_status_rpt modem_line_status_rpt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .modem_lvl   (modem_lvl),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .rpt_ready   (rpt_ready),
    .rpt_valid   (rpt_valid),
    .rpt_data    (rpt_data),
    .rpt_last    (rpt_last),
    .msr_out     (msr_out),
    .lsr_out     (lsr_out)
);

// File: tb/modem_line_status_rpt_tb_top.sv
module modem_line_status_rpt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] modem_lvl;
    logic       err_overrun, err_parity, err_framing, err_break;
    logic       rx_ready, thr_empty, tx_empty;
    logic       rd_strobe, rpt_ready;
    logic       rpt_valid, rpt_last;
    logic [7:0] rpt_data, msr_out, lsr_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    modem_line_status_rpt dut_i (
        .clk(clk), .rst_n(rst_n), .modem_lvl(modem_lvl),
        .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break),
        .rx_ready(rx_ready), .thr_empty(thr_empty), .tx_empty(tx_empty),
        .rd_strobe(rd_strobe), .rpt_ready(rpt_ready),
        .rpt_valid(rpt_valid), .rpt_data(rpt_data), .rpt_last(rpt_last),
        .msr_out(msr_out), .lsr_out(lsr_out)
    );

    // row: modem[27:24] errs{brk,fe,pe,ov}[23:20] lvl{txe,thre,rxr}[19:17] rd[16] msr[15:8] lsr[7:0]
    localparam logic [27:0] VEC [0:13] = '{
        {4'b0001, 4'b0000, 3'b000, 1'b0, 8'h11, 8'h00}, // R1 R2 CTS up
        {4'b0011, 4'b0000, 3'b000, 1'b0, 8'h33, 8'h00}, // R2 DSR up
        {4'b0111, 4'b0000, 3'b000, 1'b0, 8'h73, 8'h00}, // R3 ring rises: no flag
        {4'b0011, 4'b0000, 3'b000, 1'b0, 8'h37, 8'h00}, // R3 ring falls: flag
        {4'b0011, 4'b0000, 3'b000, 1'b1, 8'h30, 8'h00}, // R6 read clears
        {4'b1011, 4'b0000, 3'b000, 1'b1, 8'hB8, 8'h00}, // R6 event with read kept
        {4'b1011, 4'b0010, 3'b001, 1'b0, 8'hB8, 8'h85}, // R4 R5 parity
        {4'b1011, 4'b0000, 3'b111, 1'b0, 8'hB8, 8'hE5}, // R4 levels
        {4'b1011, 4'b0001, 3'b111, 1'b0, 8'hB8, 8'hE7}, // R4 overrun
        {4'b1011, 4'b0000, 3'b111, 1'b1, 8'hB0, 8'h61}, // R6 read
        {4'b1011, 4'b0001, 3'b000, 1'b0, 8'hB0, 8'h02}, // R5 overrun not in bit 7
        {4'b1011, 4'b1000, 3'b000, 1'b1, 8'hB0, 8'h90}, // R6 break kept over read
        {4'b1011, 4'b0100, 3'b000, 1'b0, 8'hB0, 8'h98}, // R5 framing
        {4'b1010, 4'b0000, 3'b000, 1'b1, 8'hA1, 8'h00}  // R6 read plus CTS drop
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_rpt(input string req, input logic v, input logic [7:0] d, input logic l);
        check({req, " valid"}, {7'd0, rpt_valid}, {7'd0, v});
        if (v) begin
            check({req, " data"}, rpt_data, d);
            check({req, " last"}, {7'd0, rpt_last}, {7'd0, l});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; modem_lvl = '0;
        err_overrun = 0; err_parity = 0; err_framing = 0; err_break = 0;
        rx_ready = 0; thr_empty = 0; tx_empty = 0; rd_strobe = 0; rpt_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 msr", msr_out, 8'h00);
        check("R10 lsr", lsr_out, 8'h00);
        check("R10 valid", {7'd0, rpt_valid}, 8'h00);

        // park one report with the sink stalled
        err_overrun = 1;
        @(negedge clk);
        err_overrun = 0;
        check("R4 overrun latched", lsr_out, 8'h02);
        @(negedge clk);
        check_rpt("R9 launched", 1'b1, 8'h00, 1'b0);
        check("R9 launch clears", lsr_out, 8'h00);

        for (int i = 0; i < 14; i++) begin
            {modem_lvl, err_break, err_framing, err_parity, err_overrun,
             tx_empty, thr_empty, rx_ready, rd_strobe} = VEC[i][27:16];
            @(negedge clk);
            check($sformatf("R1-6 row %0d msr", i), msr_out, VEC[i][15:8]);
            check($sformatf("R4/R5 row %0d lsr", i), lsr_out, VEC[i][7:0]);
        end
        {err_break, err_framing, err_parity, err_overrun, rd_strobe} = '0;
        check_rpt("R7 stalled hold", 1'b1, 8'h00, 1'b0);

        // drain: parked report, then one merged report
        rpt_ready = 1;
        @(negedge clk); check_rpt("R7 second byte", 1'b1, 8'h02, 1'b1);
        @(negedge clk); check_rpt("R7 gap", 1'b0, 8'h00, 1'b0);
        @(negedge clk); check_rpt("R9 merged msr", 1'b1, 8'hA1, 1'b0);
        check("R9 clear at launch", msr_out, 8'hA0);
        @(negedge clk); check_rpt("R9 merged lsr", 1'b1, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); check_rpt("R9 single merged report", 1'b0, 8'h00, 1'b0);
        end

        // R8 status levels alone request nothing
        rx_ready = 1; thr_empty = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); check_rpt("R8 no request on levels", 1'b0, 8'h00, 1'b0);
        end
        check("R8 levels seen", lsr_out, 8'h21);
        thr_empty = 0;
        @(negedge clk);

        // merge while in flight
        rpt_ready = 0;
        modem_lvl = 4'b1011;
        @(negedge clk);
        check("R2 CTS flag", msr_out, 8'hB1);
        modem_lvl = 4'b1111;
        @(negedge clk);
        check("R9 ring rise kept no flag", msr_out, 8'hF0);
        err_framing = 1;
        @(negedge clk);
        err_framing = 0;
        check("R5 framing", lsr_out, 8'h89);
        check_rpt("R8 ring/cts report", 1'b1, 8'hB1, 1'b0);
        rpt_ready = 1;
        @(negedge clk); check_rpt("R7 lsr byte", 1'b1, 8'h01, 1'b1);
        @(negedge clk); check_rpt("R7 gap2", 1'b0, 8'h00, 1'b0);
        @(negedge clk); check_rpt("R9 merged msr2", 1'b1, 8'hF0, 1'b0);
        @(negedge clk); check_rpt("R9 merged lsr2", 1'b1, 8'h89, 1'b1);
        @(negedge clk); check_rpt("R9 idle after", 1'b0, 8'h00, 1'b0);
        @(negedge clk); check_rpt("R9 idle after2", 1'b0, 8'h00, 1'b0);
        check("R9 cleared lsr", lsr_out, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule